// File: doc/BRIEF.md
# Stretchable CPU Clock Generator

This block derives a CPU clock from a reference clock that runs at twice the nominal CPU rate. A small synchronous counter steps once per reference edge. Its top bit is the CPU clock: high through the counting states, low for exactly one reference period. That low state always causes a reload, so the counter jumps back into its upper half and starts the next CPU cycle. The value that is reloaded sets the length of the next high phase, and so the length of the next CPU cycle, in steps of one reference period (half a CPU cycle).

An active-low device select picks the reload value. When select is inactive, the counter reloads all ones and each CPU cycle lasts two reference periods. When select is active, a configurable stretch value is reloaded instead. The decoder that drives select must settle it before the end of the low phase, because the block samples it on that edge.

A second output, the timer clock, keeps the plain divide-by-two waveform for timer peripherals. Whole-cycle stretches leave it untouched. A half-cycle stretch shifts it by one reference period, because it re-aligns to the rising CPU clock. A bypass input makes both outputs a plain divide-by-two, for debugging. A parameter chooses which counter bit drives the CPU clock.

Top module: `stretch_clock_gen`

## Requirements
- R1: On every rising reference edge the counter either increments or reloads. It reloads exactly when its most significant bit is low, so the CPU clock low phase always lasts one reference period.
- R2: When `selN` is high at the reload edge, the counter reloads all ones (hex F). The next CPU clock high phase then lasts one reference period.
- R3: When `selN` is low at the reload edge, stretch values hex D, B and 9 give high phases of 3, 5 and 7 reference periods (1, 2 and 3 extra CPU cycles). The timer clock keeps toggling every period.
- R4: When `selN` is low at the reload edge, stretch values hex E, C, A and 8 give high phases of 2, 4, 6 and 8 reference periods (0.5, 1.5, 2.5 and 3.5 extra CPU cycles). The timer clock is high in the low period that closes the cycle, so it lags by one reference period.
- R5: The timer clock toggles on every reference edge except a reload edge. On a reload edge it goes high, together with the CPU clock.
- R6: `selN` and `stretchVal` are sampled only at the reload edge. Changing them during the high phase has no effect on the cycle in progress.
- R7: Bit 3 of `stretchVal` is ignored and treated as 1. For example, a value of hex 5 behaves as hex D.
- R8: Synchronous reset (`rstN` low) sets the counter to all ones and the timer clock to 1. Both outputs are high coming out of reset, and the first cycle is unstretched.
- R9: While `bypass` is high, both outputs run as a divide-by-two of the reference clock. Asserting `bypass` during a stretched high phase ends that phase at the next reference edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Reference clock at twice the nominal CPU frequency |
| rstN | input | 1 | Synchronous active-low reset |
| selN | input | 1 | Active-low select of a slow device, sampled at the reload edge |
| stretchVal | input | 4 | Reload value used when select is active |
| bypass | input | 1 | Forces both outputs to a divide-by-two |
| cpuClk | output | 1 | Stretchable CPU clock |
| timerClk | output | 1 | Unstretched clock for timer peripherals |

## Verification
The counter state determines the CPU clock waveform directly. A wrong reload or a wrong increment therefore shows as a high phase that is too long or too short, visible on `cpuClk` within one CPU cycle. A timer flop with the wrong phase shows on `timerClk` in the low period at the end of that same cycle, because that period is the first point where a half-cycle stretch and a whole-cycle stretch predict different levels. The bench compares both outputs in every reference period against a queue of expected levels built from the stretch value chosen for each cycle.

// File: rtl/stretch_clock_gen_pkg.sv
package stretch_clock_gen_pkg;
  localparam int CNT_W = 4;

  typedef struct packed {
    logic             load;
    logic [CNT_W-1:0] reloadVal;
    logic             bypassJump;
  } ctrlStrobes_t;
endpackage

// File: rtl/stretch_ctrl.sv
module stretch_ctrl
  import stretch_clock_gen_pkg::*;
(
  input  logic             cntMsb,
  input  logic             selN,
  input  logic [CNT_W-1:0] stretchVal,
  input  logic             bypass,
  output ctrlStrobes_t     strobes
);
  localparam logic [CNT_W-1:0] UNSTRETCHED = '1;

  logic [CNT_W-1:0] selectedVal;

  // The top bit of the reload is always set, so a load always starts a high phase.
  assign selectedVal = {1'b1, stretchVal[CNT_W-2:0]};

  always_comb begin
    strobes.load       = !cntMsb;
    strobes.reloadVal  = (bypass || selN) ? UNSTRETCHED : selectedVal;
    strobes.bypassJump = bypass && cntMsb;
  end
endmodule

// File: rtl/stretch_datapath.sv
module stretch_datapath
  import stretch_clock_gen_pkg::*;
(
  input  logic             refClk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  output logic [CNT_W-1:0] count,
  output logic             timerClk
);
  always_ff @(posedge refClk) begin
    if (!rstN) begin
      count    <= '1;
      timerClk <= 1'b1;
    end else if (strobes.load) begin
      count    <= strobes.reloadVal;
      timerClk <= 1'b1;
    end else if (strobes.bypassJump) begin
      count    <= '0;
      timerClk <= ~timerClk;
    end else begin
      count    <= count + 1'b1;
      timerClk <= ~timerClk;
    end
  end
endmodule

// File: rtl/stretch_clock_gen.sv
module stretch_clock_gen
  import stretch_clock_gen_pkg::*;
#(
  parameter int TAP_BIT = CNT_W - 1
) (
  input  logic             refClk,
  input  logic             rstN,
  input  logic             selN,
  input  logic [CNT_W-1:0] stretchVal,
  input  logic             bypass,
  output logic             cpuClk,
  output logic             timerClk
);
  ctrlStrobes_t     strobes;
  logic [CNT_W-1:0] cntQ;

  stretch_ctrl u_ctrl (
    .cntMsb    (cntQ[CNT_W-1]),
    .selN      (selN),
    .stretchVal(stretchVal),
    .bypass    (bypass),
    .strobes   (strobes)
  );

  stretch_datapath u_dp (
    .refClk  (refClk),
    .rstN    (rstN),
    .strobes (strobes),
    .count   (cntQ),
    .timerClk(timerClk)
  );

  generate
    if (TAP_BIT >= 0 && TAP_BIT < CNT_W) begin : g_tap
      assign cpuClk = cntQ[TAP_BIT];
    end else begin : g_tapDefault
      assign cpuClk = cntQ[CNT_W-1];
    end
  endgenerate
endmodule

// File: rtl/stretch_clock_gen_chk.sv
module stretch_clock_gen_chk
  import stretch_clock_gen_pkg::*;
(
  input logic             refClk,
  input logic             rstN,
  input logic             selN,
  input logic             bypass,
  input logic [CNT_W-1:0] cntQ,
  input logic             timerClk
);
  logic cntMsb;
  assign cntMsb = cntQ[CNT_W-1];

  assert_low_one_period_R1: assert property (@(posedge refClk) disable iff (!rstN)
    !cntMsb |=> cntMsb);

  assert_increment_R1: assert property (@(posedge refClk) disable iff (!rstN)
    (cntMsb && !bypass && !(&cntQ)) |=> (cntQ == $past(cntQ) + 1'b1));

  assert_unstretched_reload_R2: assert property (@(posedge refClk) disable iff (!rstN)
    (!cntMsb && selN) |=> (&cntQ));

  assert_timer_realign_R5: assert property (@(posedge refClk) disable iff (!rstN)
    !cntMsb |=> timerClk);

  assert_timer_toggle_R5: assert property (@(posedge refClk) disable iff (!rstN)
    cntMsb |=> (timerClk != $past(timerClk)));

  assert_bypass_ends_phase_R9: assert property (@(posedge refClk) disable iff (!rstN)
    (cntMsb && bypass) |=> !cntQ[CNT_W-1]);
endmodule

bind stretch_clock_gen stretch_clock_gen_chk u_chk (
  .refClk  (refClk),
  .rstN    (rstN),
  .selN    (selN),
  .bypass  (bypass),
  .cntQ    (cntQ),
  .timerClk(timerClk)
);

// File: tb/stretch_clock_gen_tb.sv
`timescale 1ns/1ps
module stretch_clock_gen_tb;
  logic       refClk = 1'b0;
  logic       rstN;
  logic       selN;
  logic [3:0] stretchVal;
  logic       bypass;
  logic       cpuClk;
  logic       timerClk;

  typedef struct {
    logic  cpu;
    logic  tmr;
    string tag;
  } expItem_t;

  expItem_t expQ[$];
  int  checks = 0;
  int  errors = 0;
  bit  done = 0;

  always #2.5 refClk = ~refClk;

  stretch_clock_gen u_dut (
    .refClk    (refClk),
    .rstN      (rstN),
    .selN      (selN),
    .stretchVal(stretchVal),
    .bypass    (bypass),
    .cpuClk    (cpuClk),
    .timerClk  (timerClk)
  );

  // Monitor: one expected item per reference period, sampled after the falling edge.
  initial begin
    forever begin
      @(negedge refClk);
      #1;
      if (expQ.size() > 0) begin
        expItem_t e;
        e = expQ.pop_front();
        checks++;
        if (cpuClk !== e.cpu || timerClk !== e.tmr) begin
          errors++;
          $display("FAIL %s: cpuClk=%b timerClk=%b expected cpuClk=%b timerClk=%b",
                   e.tag, cpuClk, timerClk, e.cpu, e.tmr);
        end
      end
    end
  end

  // Driver: called at the falling edge of the low period. The inputs are set for
  // the next reload, the expected waveform is queued, and then the inputs are
  // scrambled during the high phase (R6).
  task automatic runCycle(input logic s, input logic [3:0] v, input logic byp,
                          input logic midByp, input string tag);
    int h;
    selN = s; stretchVal = v; bypass = byp;
    if (byp || s) h = 1;
    else h = 16 - int'({1'b1, v[2:0]});
    if (midByp) h = 1;
    @(posedge refClk);
    for (int k = 0; k <= h; k++) begin
      expItem_t e;
      e.cpu = (k < h);
      e.tmr = (k % 2 == 0);
      e.tag = tag;
      expQ.push_back(e);
    end
    @(negedge refClk);
    selN = ~s; stretchVal = ~v;
    if (midByp) bypass = 1'b1;
    repeat (h) @(negedge refClk);
  endtask

  initial begin
    #50000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; selN = 1'b1; stretchVal = 4'hF; bypass = 1'b0;
    repeat (4) @(negedge refClk);
    checks++;
    if (cpuClk !== 1'b1 || timerClk !== 1'b1) begin
      errors++;
      $display("FAIL R8: cpuClk=%b timerClk=%b expected cpuClk=1 timerClk=1", cpuClk, timerClk);
    end
    rstN = 1'b1;
    @(negedge refClk);
    while (cpuClk !== 1'b0) @(negedge refClk);

    runCycle(1'b1, 4'h0, 1'b0, 1'b0, "R2 unstretched");
    runCycle(1'b1, 4'hD, 1'b0, 1'b0, "R2 select inactive ignores value");
    runCycle(1'b0, 4'hD, 1'b0, 1'b0, "R3 stretch D");
    runCycle(1'b0, 4'hB, 1'b0, 1'b0, "R3 stretch B");
    runCycle(1'b0, 4'h9, 1'b0, 1'b0, "R3 stretch 9");
    runCycle(1'b0, 4'hE, 1'b0, 1'b0, "R4 stretch E");
    runCycle(1'b0, 4'hC, 1'b0, 1'b0, "R4 stretch C");
    runCycle(1'b0, 4'hA, 1'b0, 1'b0, "R4 stretch A");
    runCycle(1'b0, 4'h8, 1'b0, 1'b0, "R4 R5 stretch 8");
    runCycle(1'b1, 4'hF, 1'b0, 1'b0, "R1 R6 back to unstretched");
    runCycle(1'b0, 4'h5, 1'b0, 1'b0, "R7 msb ignored, 5 acts as D");
    runCycle(1'b0, 4'h0, 1'b0, 1'b0, "R7 msb ignored, 0 acts as 8");
    runCycle(1'b0, 4'hB, 1'b1, 1'b0, "R9 bypass divide-by-two");
    runCycle(1'b0, 4'h9, 1'b1, 1'b0, "R9 bypass holds");
    runCycle(1'b0, 4'h9, 1'b0, 1'b1, "R9 bypass cuts stretch short");
    runCycle(1'b0, 4'hE, 1'b0, 1'b0, "R4 R6 half stretch after bypass");
    runCycle(1'b1, 4'h8, 1'b0, 1'b0, "R2 final unstretched");

    while (expQ.size() > 0) @(negedge refClk);
    #2;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule